// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Suspend

This block is the write state machine behind a NOR-style flash model. It takes commands that an upstream decoder has already recognised: word program, sector erase, suspend, resume and entry into single-pulse program mode. It then runs timed program and erase operations against a small behavioural word array. Operation times are cycle counts set by parameters. A program clears bits (the new word is the old word ANDed with the data) and an erase sets every word of a sector to all ones.

Completion can be observed in two ways: the `rdy` output, or polling reads. A read issued while an operation runs returns a status word instead of array data. The sequencer supports erase suspend and program suspend. While an erase is suspended, the host may read and program sectors other than the one being erased. While a program is suspended, the host may read words outside that program's sector. Reads of protected locations are refused and flagged. Single-pulse mode turns every command into a word program, and only a long reset pulse or power-on reset leaves it.

States: `ST_READ` (idle, array reads), `ST_PROG` (word program running), `ST_ERASE` (sector erase running), `ST_ESUSP` (erase suspended), `ST_ES_PROG` (program running inside an erase suspend), `ST_PSUSP` (program suspended). The transitions are:
- READ→PROG on a program command, or on any command in single-pulse mode.
- READ→ERASE on an erase command.
- PROG→READ when the program count ends.
- PROG→PSUSP on a suspend command, outside single-pulse mode.
- PSUSP→PROG on a resume command.
- ERASE→READ when the erase count ends.
- ERASE→ESUSP on a suspend command.
- ESUSP→ERASE on a resume command.
- ESUSP→ES_PROG on a program command to another sector.
- ES_PROG→ESUSP when that program's count ends.
- Any state→READ while `rst_n` is low.

Top module: `flash_wsm`

## Requirements
- R1: After `por_n` is released, the block is in read mode: `rdy` is 1, and every word reads 0xFFFF.
- R2: A program command (`cmd_op`=0) drops `rdy` for exactly PROG_CYC cycles. After that, the addressed word holds its old value ANDed with `cmd_data`.
- R3: An erase command (`cmd_op`=1) drops `rdy` for exactly ERASE_CYC cycles of active erase. It then sets every word of the sector `cmd_addr[ADDR_W-1 -: SECT_W]` to all ones and leaves other sectors unchanged.
- R4: A read issued while busy returns `rd_stat`=1 and a status word. Bit 7 is the complement of bit 7 of the value being written (an erase writes 1, so bit 7 reads 0). Bit 6 is 0 on the first status read after reset and inverts on each later status read. All other bits are 0.
- R5: A suspend command (`cmd_op`=2) during an erase sets `rdy` to 1 from the next cycle. Reads outside the erase sector then return array data. Reads inside it return `rd_deny`=1, with `rd_data`=0 and `rd_stat`=0.
- R6: While an erase is suspended, a program to another sector runs for PROG_CYC cycles and the block returns to the erase-suspended state. A program to the erase sector is ignored.
- R7: A suspend command during a program sets `rdy` to 1 from the next cycle. Reads outside that program's sector return array data. Reads inside it are refused with `rd_deny`=1.
- R8: A resume command (`cmd_op`=3) continues the suspended operation. The busy cycles before and after the suspension add up to the full operation count.
- R9: Commands that do not apply in the current state have no effect. Examples: any command other than suspend while busy, or resume in read mode.
- R10: After the single-pulse entry command (`cmd_op`=4), every command in read mode is a program of `cmd_data` to `cmd_addr`, whatever its op code. A suspend while busy in this mode is ignored.
- R11: While `rst_n` is low, any operation is aborted and the block returns to read mode. Single-pulse mode ends only if `rst_n` stays low for at least RST_MIN cycles.
- R12: A read (`rd_en`) gives `rd_valid` with its result exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Reset pin, synchronous, active low |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | 0 program, 1 erase, 2 suspend, 3 resume, 4 single-pulse entry |
| cmd_addr | input | ADDR_W | Word address for program or erase |
| cmd_data | input | DATA_W | Program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rdy | output | 1 | 1 when ready or suspended, 0 when busy |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Array word or status word |
| rd_stat | output | 1 | rd_data holds a status word |
| rd_deny | output | 1 | Read refused during a suspend |

## Verification
A wrong state register or timer shows up at `rdy` in the same cycle it goes wrong. It also shows up in the next read result, which arrives one cycle later. A timer that does not freeze while suspended shows up as a wrong total of busy cycles across a suspend/resume pair. A lost single-pulse flag shows up only at the next command, because an erase then takes ERASE_CYC cycles instead of PROG_CYC. The bench drives each of these paths and compares every port against its own model on every clock.

// File: rtl/flash_wsm_pkg.sv
`timescale 1ns/1ps
package flash_wsm_pkg;
    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_ERASE  = 3'd1,
        OP_SUSP   = 3'd2,
        OP_RESUME = 3'd3,
        OP_SPM    = 3'd4
    } wsm_op_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ERASE,
        ST_ESUSP,
        ST_ES_PROG,
        ST_PSUSP
    } wsm_state_e;
endpackage

// File: rtl/wsm_timer.sv
`timescale 1ns/1ps
module wsm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               cnt_q <= '0;
        else if (clr)             cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Counter only moves while run is high, so it freezes in suspend.
    assign last = run && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wsm_array.sv
`timescale 1ns/1ps
module wsm_array #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [SECT_W-1:0] erase_sect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                word_q <= '1;
            else if (erase_en && WA[ADDR_W-1 -: SECT_W] == erase_sect)
                word_q <= '1;
            else if (prog_en && prog_addr == WA)
                word_q <= word_q & prog_data;
        end

        assign words[w] = word_q;
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/flash_wsm.sv
`timescale 1ns/1ps
module flash_wsm
    import flash_wsm_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 2,
    parameter int DATA_W    = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20,
    parameter int RST_MIN   = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rdy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stat,
    output logic              rd_deny
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    localparam int LOW_W = $clog2(RST_MIN + 1);

    wsm_state_e        state_q, state_d;
    wsm_op_e           op;
    logic              sp_q;
    logic [LOW_W-1:0]  low_q;
    logic [ADDR_W-1:0] pa_q;
    logic [DATA_W-1:0] pd_q;
    logic [SECT_W-1:0] es_q;
    logic              tog_q;

    logic cap_prog, cap_erase, set_sp, prog_commit, erase_commit;
    logic p_run, e_run, p_last, e_last;
    logic [SECT_W-1:0] cmd_sect, rd_sect, pa_sect;
    logic [DATA_W-1:0] arr_word, stat_word;

    assign op       = wsm_op_e'(cmd_op);
    assign cmd_sect = cmd_addr[ADDR_W-1 -: SECT_W];
    assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_W];
    assign pa_sect  = pa_q[ADDR_W-1 -: SECT_W];

    // Next state and transition strobes
    always_comb begin
        state_d      = state_q;
        cap_prog     = 1'b0;
        cap_erase    = 1'b0;
        set_sp       = 1'b0;
        prog_commit  = 1'b0;
        erase_commit = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (cmd_valid) begin
                    if (sp_q || op == OP_PROG) begin
                        cap_prog = 1'b1;
                        state_d  = ST_PROG;
                    end else if (op == OP_ERASE) begin
                        cap_erase = 1'b1;
                        state_d   = ST_ERASE;
                    end else if (op == OP_SPM) begin
                        set_sp = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (p_last) begin
                    prog_commit = 1'b1;
                    state_d     = ST_READ;
                end else if (cmd_valid && op == OP_SUSP && !sp_q) begin
                    state_d = ST_PSUSP;
                end
            end
            ST_ERASE: begin
                if (e_last) begin
                    erase_commit = 1'b1;
                    state_d      = ST_READ;
                end else if (cmd_valid && op == OP_SUSP) begin
                    state_d = ST_ESUSP;
                end
            end
            ST_ESUSP: begin
                if (cmd_valid) begin
                    if (op == OP_RESUME) begin
                        state_d = ST_ERASE;
                    end else if (op == OP_PROG && cmd_sect != es_q) begin
                        cap_prog = 1'b1;
                        state_d  = ST_ES_PROG;
                    end
                end
            end
            ST_ES_PROG: begin
                if (p_last) begin
                    prog_commit = 1'b1;
                    state_d     = ST_ESUSP;
                end
            end
            ST_PSUSP: begin
                if (cmd_valid && op == OP_RESUME) state_d = ST_PROG;
            end
            default: state_d = ST_READ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      state_q <= ST_READ;
        else if (!rst_n) state_q <= ST_READ;
        else             state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        rdy   = (state_q == ST_READ) || (state_q == ST_ESUSP) || (state_q == ST_PSUSP);
        p_run = (state_q == ST_PROG) || (state_q == ST_ES_PROG);
        e_run = (state_q == ST_ERASE);
        stat_word    = '0;
        stat_word[7] = (state_q == ST_ERASE) ? 1'b0 : ~pd_q[7];
        stat_word[6] = tog_q;
    end

    // Operation operands
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pa_q <= '0;
            pd_q <= '0;
            es_q <= '0;
        end else if (rst_n) begin
            if (cap_prog) begin
                pa_q <= cmd_addr;
                pd_q <= cmd_data;
            end
            if (cap_erase) es_q <= cmd_sect;
        end
    end

    // Single-pulse mode flag and reset-width counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sp_q  <= 1'b0;
            low_q <= '0;
        end else if (!rst_n) begin
            if (low_q != LOW_W'(RST_MIN)) low_q <= low_q + 1'b1;
            if (low_q >= LOW_W'(RST_MIN - 1)) sp_q <= 1'b0;
        end else begin
            low_q <= '0;
            if (set_sp) sp_q <= 1'b1;
        end
    end

    // Registered read path
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_stat  <= 1'b0;
            rd_deny  <= 1'b0;
            tog_q    <= 1'b0;
        end else if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_stat  <= 1'b0;
            rd_deny  <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= '0;
            rd_stat  <= 1'b0;
            rd_deny  <= 1'b0;
            if (rd_en) begin
                if (!rdy) begin
                    rd_stat <= 1'b1;
                    rd_data <= stat_word;
                    tog_q   <= ~tog_q;
                end else if ((state_q == ST_ESUSP && rd_sect == es_q) ||
                             (state_q == ST_PSUSP && rd_sect == pa_sect)) begin
                    rd_deny <= 1'b1;
                end else begin
                    rd_data <= arr_word;
                end
            end
        end
    end

    wsm_timer #(.CNT_W(CNT_W)) u_ptimer (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (!rst_n),
        .load     (cap_prog),
        .load_val (CNT_W'(PROG_CYC)),
        .run      (p_run),
        .last     (p_last)
    );

    wsm_timer #(.CNT_W(CNT_W)) u_etimer (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (!rst_n),
        .load     (cap_erase),
        .load_val (CNT_W'(ERASE_CYC)),
        .run      (e_run),
        .last     (e_last)
    );

    wsm_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .por_n      (por_n),
        .prog_en    (prog_commit && rst_n),
        .prog_addr  (pa_q),
        .prog_data  (pd_q),
        .erase_en   (erase_commit && rst_n),
        .erase_sect (es_q),
        .rd_addr    (rd_addr),
        .rd_word    (arr_word)
    );
endmodule

// File: rtl/flash_wsm_chk.sv
`timescale 1ns/1ps
module flash_wsm_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rdy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_stat,
    input logic              rd_deny
);
    AST_RST_TO_READY: assert property (@(posedge clk) disable iff (!por_n) !rst_n |=> rdy); // R11
    AST_DENY_CLEAN: assert property (@(posedge clk) disable iff (!por_n) (rd_valid && rd_deny) |-> (!rd_stat && rd_data == '0)); // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!por_n || !rst_n) rd_en |=> rd_valid); // R12
    AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (!por_n) rd_valid |-> $past(rd_en)); // R12
    AST_STAT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!por_n || !rst_n) (rd_valid && rd_stat) |-> $past(!rdy)); // R4
endmodule

bind flash_wsm flash_wsm_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_wsm_tb_top.sv
`timescale 1ns/1ps
module flash_wsm_tb_top;
    localparam int AW = 6, DW = 16, PC = 8, EC = 20, RM = 4;

    logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, rd_en = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic rdy, rd_valid, rd_stat, rd_deny;
    logic [DW-1:0] rd_data;

    int checks = 0, failures = 0, bc = 0, n1 = 0, cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_wsm dut_i (.*);

    // Behavioural reference model
    logic [DW-1:0] mm [64];
    int st, pc, ec, es, pa, low;
    logic [DW-1:0] pd;
    logic tog, sp, mv, ms, mdn;
    logic [DW-1:0] md;

    function automatic int sec(input int a); return a / 16; endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < 64; i++) mm[i] = 16'hFFFF;
            st = 0; pc = 0; ec = 0; es = 0; pa = 0; pd = 0; low = 0;
            tog = 0; sp = 0; mv = 0; ms = 0; mdn = 0; md = 0;
        end else if (!rst_n) begin
            st = 0; pc = 0; ec = 0; tog = 0; mv = 0; ms = 0; mdn = 0; md = 0;
            low = low + 1;
            if (low >= RM) sp = 0;
        end else begin
            low = 0; mv = rd_en; ms = 0; mdn = 0; md = 0;
            if (rd_en) begin
                if (st == 1 || st == 2 || st == 4) begin
                    ms = 1;
                    md = ((st == 2) ? 16'h0 : {8'h0, ~pd[7], 7'h0}) | (tog ? 16'h40 : 16'h0);
                    tog = !tog;
                end else if ((st == 3 && sec(int'(rd_addr)) == es) ||
                             (st == 5 && sec(int'(rd_addr)) == sec(pa))) mdn = 1;
                else md = mm[rd_addr];
            end
            case (st)
                1, 4: begin
                    pc = pc - 1;
                    if (pc == 0) begin mm[pa] = mm[pa] & pd; st = (st == 1) ? 0 : 3; end
                    else if (st == 1 && cmd_valid && cmd_op == 2 && !sp) st = 5;
                end
                2: begin
                    ec = ec - 1;
                    if (ec == 0) begin
                        for (int i = 0; i < 64; i++) if (sec(i) == es) mm[i] = 16'hFFFF;
                        st = 0;
                    end else if (cmd_valid && cmd_op == 2) st = 3;
                end
                0: if (cmd_valid) begin
                    if (sp || cmd_op == 0) begin pa = int'(cmd_addr); pd = cmd_data; pc = PC; st = 1; end
                    else if (cmd_op == 1) begin es = sec(int'(cmd_addr)); ec = EC; st = 2; end
                    else if (cmd_op == 4) sp = 1;
                end
                3: if (cmd_valid) begin
                    if (cmd_op == 3) st = 2;
                    else if (cmd_op == 0 && sec(int'(cmd_addr)) != es) begin
                        pa = int'(cmd_addr); pd = cmd_data; pc = PC; st = 4;
                    end
                end
                5: if (cmd_valid && cmd_op == 3) st = 1;
                default: st = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (por_n) begin
            logic mrdy;
            mrdy = (st == 0 || st == 3 || st == 5);
            checks++;
            if (rdy !== mrdy || rd_valid !== mv) begin
                failures++;
                $display("FAIL %s rdy/valid act=%b/%b exp=%b/%b", cur_req, rdy, rd_valid, mrdy, mv);
            end
            if (mv && (rd_data !== md || rd_stat !== ms || rd_deny !== mdn)) begin
                failures++;
                $display("FAIL %s read act=%h/%b/%b exp=%h/%b/%b", cur_req, rd_data, rd_stat, rd_deny, md, ms, mdn);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<=20000", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        if (!rdy) bc++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input int a, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input int a);
        rd_en = 1'b1; rd_addr = AW'(a);
        step();
        rd_en = 1'b0;
    endtask

    task automatic wait_rdy();
        while (!rdy) step();
    endtask

    initial begin
        repeat (3) step();
        por_n = 1'b1;
        step();
        rst_n = 1'b1;
        step();
        cur_req = "R1";
        chk("R1 ready", 32'(rdy), 1);
        rd(5); chk("R1 erased", 32'(rd_data), 32'hFFFF);
        chk("R12 valid", 32'(rd_valid), 1);

        cur_req = "R2"; bc = 0;
        cmd(0, 5, 16'h1234);
        chk("R2 busy", 32'(rdy), 0);
        rd(5); chk("R4 first status", {rd_stat, rd_data}, 32'h10080);
        rd(5); chk("R4 toggled status", {rd_stat, rd_data}, 32'h100C0);
        wait_rdy(); chk("R2 duration", bc, PC);
        rd(5); chk("R2 data", 32'(rd_data), 32'h1234);

        cur_req = "R9"; bc = 0;
        cmd(0, 5, 16'hFF00);
        cmd(0, 6, 16'h0000);
        wait_rdy(); chk("R2 and-merge duration", bc, PC);
        rd(5); chk("R2 and-merge", 32'(rd_data), 32'h1200);
        rd(6); chk("R9 busy cmd ignored", 32'(rd_data), 32'hFFFF);
        cmd(3, 0, 0); chk("R9 resume in read", 32'(rdy), 1);

        cur_req = "R5";
        cmd(0, 20, 16'hABCD); wait_rdy();
        bc = 0;
        cmd(1, 3, 0);
        rd(9); chk("R4 erase status", {rd_stat, rd_data}, 32'h10000);
        repeat (3) step();
        cmd(2, 0, 0); n1 = bc;
        chk("R5 suspend ready", 32'(rdy), 1);
        rd(20); chk("R5 other sector", 32'(rd_data), 32'hABCD);
        rd(5); chk("R5 denied", {rd_deny, rd_data}, 32'h10000);
        cur_req = "R6";
        cmd(0, 7, 16'h0000); chk("R6 same sector ignored", 32'(rdy), 1);
        bc = 0;
        cmd(0, 33, 16'h0F0F); wait_rdy();
        chk("R6 program in suspend", bc, PC);
        rd(5); chk("R6 back to suspend", 32'(rd_deny), 1);
        rd(33); chk("R6 data", 32'(rd_data), 32'h0F0F);
        cur_req = "R8"; bc = 0;
        cmd(3, 0, 0); wait_rdy();
        chk("R8 erase total", n1 + bc, EC);
        rd(5); chk("R3 erased", 32'(rd_data), 32'hFFFF);
        rd(7); chk("R6 same-sector program lost", 32'(rd_data), 32'hFFFF);
        rd(20); chk("R3 other sector kept", 32'(rd_data), 32'hABCD);

        cur_req = "R7"; bc = 0;
        cmd(0, 40, 16'h00F0); step(); step();
        cmd(2, 0, 0); n1 = bc;
        chk("R7 suspend ready", 32'(rdy), 1);
        rd(41); chk("R7 denied", 32'(rd_deny), 1);
        rd(10); chk("R7 other sector", 32'(rd_data), 32'hFFFF);
        bc = 0;
        cmd(3, 0, 0); wait_rdy();
        chk("R8 program total", n1 + bc, PC);
        rd(40); chk("R7 data", 32'(rd_data), 32'h00F0);

        cur_req = "R10";
        cmd(4, 0, 0); chk("R10 entry no op", 32'(rdy), 1);
        bc = 0;
        cmd(1, 50, 16'h5555); chk("R10 erase as program", 32'(rdy), 0);
        cmd(2, 0, 0); chk("R10 suspend ignored", 32'(rdy), 0);
        wait_rdy(); chk("R10 duration", bc, PC);
        rd(50); chk("R10 data", 32'(rd_data), 32'h5555);
        rd(49); chk("R10 no erase", 32'(rd_data), 32'hFFFF);

        cur_req = "R11";
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        cmd(3, 51, 16'h3333); wait_rdy();
        rd(51); chk("R11 short reset keeps mode", 32'(rd_data), 32'h3333);
        cmd(0, 52, 16'h0000); step();
        rst_n = 1'b0; step(); step();
        chk("R11 abort ready", 32'(rdy), 1);
        rst_n = 1'b1;
        rd(52); chk("R11 aborted program", 32'(rd_data), 32'hFFFF);
        rst_n = 1'b0; repeat (RM) step(); rst_n = 1'b1;
        bc = 0;
        cmd(1, 50, 0); wait_rdy();
        chk("R11 long reset exits mode", bc, EC);
        rd(51); chk("R3 sector erased", 32'(rd_data), 32'hFFFF);
        rd(33); chk("R3 neighbour kept", 32'(rd_data), 32'h0F0F);
        step();
        finish_run();
    end
endmodule